// File: doc/BRIEF.md
# External Interrupt Request Latch Controller

This block turns one active-low external interrupt pin into a latched interrupt request for a CPU. The pin passes through a two-stage synchronizer. A falling edge of the synchronized level sets a request latch. A CPU vector-fetch strobe clears the latch, and so does software writing 1 to the acknowledge field of a small control register. A mode field selects how the pin is sensed. In edge mode any acknowledge clears the latch at once. In level mode the latch stays set while the pin is low. An acknowledge that arrives during that time is remembered, and the latch clears only once the pin is high again. The two conditions can occur in either order.

A mask field gates only the request sent to the CPU. The pending flag always shows the raw latch, so software can poll it. During a debug break, software acknowledges take effect only while the break-clear-enable input is 1. The block also outputs the synchronized pin level and a constant handler vector address.

Top module: `extirq_ctrl`

## Requirements
- R1: A falling edge on `irq_pin_n` sets `irq_pending` within three rising clock edges of the pin change, counted after the two-stage synchronizer. If the synchronized level has not changed, a clear latch stays clear.
- R2: In edge mode (control bit 0 = 0), a `vec_fetch_ack` pulse or a register write with bit 2 = 1 clears the latch on the next edge, even while the pin stays low. The latch does not set again until a new falling edge arrives.
- R3: In level mode (control bit 0 = 1), an acknowledge that arrives while the pin is low leaves the latch set. The acknowledge is remembered, and the latch clears when the synchronized pin level goes high.
- R4: In level mode, the pin returning high without an acknowledge leaves the latch set. A later acknowledge then clears it.
- R5: An acknowledge that arrives while nothing is pending is not remembered. A later falling edge latches a request that stays set after the pin returns high.
- R6: `cpu_irq_req` equals pending AND NOT mask, where the mask is control bit 1. `irq_pending` ignores the mask.
- R7: While `in_break` = 1, a software acknowledge has effect only if `brk_clr_en` = 1. A latch cleared during a break stays clear after `in_break` drops.
- R8: Reset clears the latch, the mode bit and the mask bit. A pin held low through reset and release does not produce a request.
- R9: Register read layout: bit 0 = mode, bit 1 = mask, bit 2 = acknowledge (always reads 0), bit 3 = pending, and all higher bits read 0. Write bits 0 and 1 store mode and mask.
- R10: `pin_level` shows the synchronized pin level. `vec_addr` is the constant handler address 0xFFFA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_pin_n | input | 1 | External interrupt pin, active low, asynchronous |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 3 | Write data: bit 0 mode, bit 1 mask, bit 2 acknowledge |
| reg_rdata | output | DATA_W | Control/status read value |
| vec_fetch_ack | input | 1 | CPU vector-fetch acknowledge strobe |
| in_break | input | 1 | Debug break state |
| brk_clr_en | input | 1 | Allows software clears during break |
| cpu_irq_req | output | 1 | Masked request to the CPU |
| irq_pending | output | 1 | Unmasked latched request |
| pin_level | output | 1 | Synchronized pin level |
| vec_addr | output | ADDR_W | Handler vector address |

## Verification
The bench acknowledges while the pin is still low in both modes. A design that ignores the mode would either keep the request in edge mode or drop it too early in level mode. It checks the remembered acknowledge in level mode, in both orders, and that an acknowledge given while idle is not stored; a design that records every acknowledge would drop a later level request as soon as the pin returns high. It also holds the pin low through a reset. A synchronizer that resets to the idle level and is not primed would create a false edge and a spurious request. Finally, it issues software clears during a break with the enable both low and high, and confirms that a clear made during the break persists afterwards.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  // Control register field positions
  localparam int FLD_MODE = 0;
  localparam int FLD_MASK = 1;
  localparam int FLD_ACK  = 2;
  localparam int FLD_PEND = 3;
  // Writable field width
  localparam int CTL_WR_W = 3;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_lvl,
  output logic fall
);
  localparam int PRIME_W = STAGES + 1;

  logic [STAGES-1:0]  sh_q, sh_d;
  logic               prev_q, prev_d;
  logic [PRIME_W-1:0] vld_q, vld_d;

  assign sh_d[0] = pin_n;
  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_chain
      assign sh_d[gi] = sh_q[gi-1];
    end
  endgenerate

  assign pin_lvl = sh_q[STAGES-1];

  always_comb begin
    prev_d = pin_lvl;
    vld_d  = {vld_q[PRIME_W-2:0], 1'b1};
  end

  // An edge counts only once the previous sample holds a real pin value
  assign fall = vld_q[PRIME_W-1] & prev_q & ~pin_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
      vld_q  <= '0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
      vld_q  <= vld_d;
    end
  end
endmodule

// File: rtl/extirq_latch.sv
module extirq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic level_mode,
  input  logic fall,
  input  logic pin_lvl,
  input  logic ack_evt,
  output logic pending
);
  logic lat_q, lat_d;
  logic ackd_q, ackd_d;

  always_comb begin
    lat_d  = lat_q;
    ackd_d = ackd_q;
    if (fall) begin
      lat_d  = 1'b1;
      ackd_d = 1'b0;
    end else if (lat_q) begin
      if (!level_mode) begin
        ackd_d = 1'b0;
        if (ack_evt) lat_d = 1'b0;
      end else if ((ack_evt || ackd_q) && pin_lvl) begin
        lat_d  = 1'b0;
        ackd_d = 1'b0;
      end else if (ack_evt) begin
        ackd_d = 1'b1;
      end
    end else begin
      ackd_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= 1'b0;
      ackd_q <= 1'b0;
    end else begin
      lat_q  <= lat_d;
      ackd_q <= ackd_d;
    end
  end

  assign pending = lat_q;
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CTL_WR_W-1:0] wdata,
  input  logic                in_break,
  input  logic                brk_clr_en,
  input  logic                pending,
  output logic                mode,
  output logic                mask,
  output logic                sw_ack,
  output logic [DATA_W-1:0]   rdata
);
  logic mode_q, mode_d;
  logic mask_q, mask_d;
  logic clr_allowed;

  assign clr_allowed = ~in_break | brk_clr_en;
  assign sw_ack      = wr_en & wdata[FLD_ACK] & clr_allowed;

  always_comb begin
    mode_d = mode_q;
    mask_d = mask_q;
    if (wr_en) begin
      mode_d = wdata[FLD_MODE];
      mask_d = wdata[FLD_MASK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    rdata           = '0;
    rdata[FLD_MODE] = mode_q;
    rdata[FLD_MASK] = mask_q;
    rdata[FLD_PEND] = pending;
  end

  assign mode = mode_q;
  assign mask = mask_q;
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 16,
  parameter logic [15:0] VEC_BASE    = 16'hFFFA
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_pin_n,
  input  logic                reg_wr_en,
  input  logic [CTL_WR_W-1:0] reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                vec_fetch_ack,
  input  logic                in_break,
  input  logic                brk_clr_en,
  output logic                cpu_irq_req,
  output logic                irq_pending,
  output logic                pin_level,
  output logic [ADDR_W-1:0]   vec_addr
);
  logic fall, pin_lvl, mode, mask, sw_ack, pending;

  extirq_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n),
    .pin_lvl(pin_lvl), .fall(fall)
  );

  extirq_regs #(.DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .in_break(in_break), .brk_clr_en(brk_clr_en), .pending(pending),
    .mode(mode), .mask(mask), .sw_ack(sw_ack), .rdata(reg_rdata)
  );

  extirq_latch latch_i (
    .clk(clk), .rst_n(rst_n), .level_mode(mode), .fall(fall),
    .pin_lvl(pin_lvl), .ack_evt(vec_fetch_ack | sw_ack), .pending(pending)
  );

  assign irq_pending = pending;
  assign cpu_irq_req = pending & ~mask;
  assign pin_level   = pin_lvl;
  assign vec_addr    = ADDR_W'(VEC_BASE);
endmodule

// File: rtl/extirq_ctrl_chk.sv
module extirq_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              vec_fetch_ack,
  input logic              in_break,
  input logic              brk_clr_en,
  input logic              cpu_irq_req,
  input logic              irq_pending,
  input logic              pin_level
);
  AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_pending && pin_level == $past(pin_level)) |=> !irq_pending); // R1

  AST_EDGE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[0] && vec_fetch_ack && pin_level == $past(pin_level)) |=> !irq_pending); // R2

  AST_LEVEL_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[0] && irq_pending && !pin_level) |=> irq_pending); // R3

  AST_BREAK_BLOCKS_SW: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata[0] && in_break && !brk_clr_en && !vec_fetch_ack && irq_pending) |=> irq_pending); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (reg_rdata == '0 && !cpu_irq_req)); // R8
endmodule

bind extirq_ctrl extirq_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata),
  .vec_fetch_ack(vec_fetch_ack), .in_break(in_break), .brk_clr_en(brk_clr_en),
  .cpu_irq_req(cpu_irq_req), .irq_pending(irq_pending), .pin_level(pin_level)
);

// File: tb/extirq_ctrl_tb_top.sv
`timescale 1ns/1ps
module extirq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_n, wr_en, vack, brk, bce;
  logic [2:0] wdata;
  logic [7:0] rdata;
  logic       req, pend, plvl;
  logic [15:0] vaddr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk; // 200 MHz

  extirq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(pin_n), .reg_wr_en(wr_en),
    .reg_wdata(wdata), .reg_rdata(rdata), .vec_fetch_ack(vack),
    .in_break(brk), .brk_clr_en(bce), .cpu_irq_req(req),
    .irq_pending(pend), .pin_level(plvl), .vec_addr(vaddr)
  );

  typedef struct packed {
    logic       pin;  logic wr; logic ak; logic mk; logic md;
    logic       va;   logic bk; logic bc; logic ep; logic er;
    logic [3:0] rq;
  } step_t;

  localparam int NSTEP = 32;
  // pin wr ack mask mode vack brk bce | exp_pend exp_req | req
  localparam step_t TBL [NSTEP] = '{
    '{1,0,0,0,0,0,0,0, 0,0, 4'd1},  // R1 idle
    '{0,0,0,0,0,0,0,0, 1,1, 4'd1},  // R1 edge sets
    '{0,1,1,0,0,0,0,0, 0,0, 4'd2},  // R2 sw ack, pin low
    '{1,0,0,0,0,0,0,0, 0,0, 4'd2},  // R2 rise no set
    '{0,0,0,0,0,0,0,0, 1,1, 4'd1},  // R1 new edge
    '{0,0,0,0,0,1,0,0, 0,0, 4'd2},  // R2 vector ack
    '{1,0,0,0,0,0,0,0, 0,0, 4'd2},
    '{1,1,0,1,0,0,0,0, 0,0, 4'd6},  // R6 mask on
    '{0,0,0,0,0,0,0,0, 1,0, 4'd6},  // R6 pending, req masked
    '{0,1,0,0,0,0,0,0, 1,1, 4'd6},  // R6 unmask
    '{1,0,0,0,0,0,0,0, 1,1, 4'd2},  // R2 edge mode holds w/o ack
    '{1,0,0,0,0,1,0,0, 0,0, 4'd2},
    '{1,1,0,0,1,0,0,0, 0,0, 4'd3},  // R3 level mode on
    '{0,0,0,0,0,0,0,0, 1,1, 4'd3},
    '{0,0,0,0,0,1,0,0, 1,1, 4'd3},  // R3 ack while low holds
    '{1,0,0,0,0,0,0,0, 0,0, 4'd3},  // R3 rise completes clear
    '{0,0,0,0,0,0,0,0, 1,1, 4'd4},
    '{1,0,0,0,0,0,0,0, 1,1, 4'd4},  // R4 rise alone holds
    '{1,1,1,0,1,0,0,0, 0,0, 4'd4},  // R4 ack after rise clears
    '{0,0,0,0,0,0,0,0, 1,1, 4'd3},
    '{0,0,0,0,0,1,0,0, 1,1, 4'd3},
    '{1,0,0,0,0,0,0,0, 0,0, 4'd3},
    '{1,0,0,0,0,1,0,0, 0,0, 4'd5},  // R5 idle ack
    '{0,0,0,0,0,0,0,0, 1,1, 4'd5},
    '{1,0,0,0,0,0,0,0, 1,1, 4'd5},  // R5 idle ack not stored
    '{1,0,0,0,0,1,0,0, 0,0, 4'd5},
    '{1,1,0,0,0,0,0,0, 0,0, 4'd7},  // back to edge mode
    '{0,0,0,0,0,0,0,0, 1,1, 4'd7},
    '{0,1,1,0,0,0,1,0, 1,1, 4'd7},  // R7 gated in break
    '{0,1,1,0,0,0,1,1, 0,0, 4'd7},  // R7 enabled in break
    '{0,0,0,0,0,0,0,0, 0,0, 4'd7},  // R7 stays clear after break
    '{1,0,0,0,0,0,0,0, 0,0, 4'd7}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; pin_n = 1'b1; wr_en = 0; wdata = '0; vack = 0; brk = 0; bce = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset rdata", 16'(rdata), 16'h0000);
    chk("R8 reset req", 16'(req), 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NSTEP; i++) begin
      pin_n = TBL[i].pin; wr_en = TBL[i].wr;
      wdata = {TBL[i].ak, TBL[i].mk, TBL[i].md};
      vack = TBL[i].va; brk = TBL[i].bk; bce = TBL[i].bc;
      @(negedge clk);
      wr_en = 0; vack = 0;
      repeat (3) @(negedge clk);
      chk($sformatf("R%0d step %0d pending", TBL[i].rq, i), 16'(pend), 16'(TBL[i].ep));
      chk($sformatf("R%0d step %0d req", TBL[i].rq, i), 16'(req), 16'(TBL[i].er));
    end
    brk = 0; bce = 0;

    // R9 register layout: write all fields, ack reads 0
    wr_en = 1; wdata = 3'b111;
    @(negedge clk);
    wr_en = 0;
    chk("R9 rdata after write", 16'(rdata), 16'h0003);
    chk("R10 vec_addr", vaddr, 16'hFFFA);
    chk("R10 pin_level high", 16'(plvl), 16'h1);

    pin_n = 0;
    repeat (4) @(negedge clk);
    chk("R9 rdata pending", 16'(rdata), 16'h000B);
    chk("R6 masked req", 16'(req), 16'h0);
    chk("R10 pin_level low", 16'(plvl), 16'h0);

    // R8 reset in level mode with pin held low
    rst_n = 0;
    @(negedge clk);
    chk("R8 reset drops pending", 16'(rdata), 16'h0000);
    rst_n = 1;
    repeat (8) @(negedge clk);
    chk("R8 no request from held pin", 16'(pend), 16'h0);
    chk("R8 mode/mask cleared", 16'(rdata), 16'h0000);

    pin_n = 1;
    repeat (4) @(negedge clk);
    pin_n = 0;
    repeat (4) @(negedge clk);
    chk("R1 edge after reset", 16'(pend), 16'h1);

    done = 1;
    finish_run();
  end
endmodule